// File: doc/BRIEF.md
# Layer Boundary Point Classifier

This block sits in a scanline design-rule checking pipeline for Manhattan layouts. It takes the merged point stream of one scanline, one point per cycle, and decides which points lie on the boundary of the union of all shapes on their layer. Every mask layer has a pair of signed counters. One tracks whether the area just below the current point is covered on the left of the scanline. The other tracks the same on the right. Shapes that overlap or coincide add to these counters, so the union comes out without any geometric merging.

For each point, the block updates the counters of the point's layer from the point's kind and edge orientation. It then tags the point as a boundary point, a boundary endpoint, or neither. The tagged point leaves one cycle later on the main output. A second output in the same cycle carries the point that the next scanline inherits: a started edge becomes an inherited point, an inherited point or an extension point travels on unchanged, and some ending endpoints spawn an extension point whose reach is the layer's largest width or spacing limit. A layer code of zero marks the start of a new X position and clears every counter.

A point kind is carried on two bits, p and d. p=0,d=0 is an edge start. p=0,d=1 is an edge end. p=1,d=1 is an inherited point. p=1,d=0 is an extension point. The orientation bit is 0 for an edge that bounds its shape from above and 1 for one that bounds it from below.

Top module: `true_point_selector`

## Requirements
- R1: A point with layer code 0 is a scanline marker. It clears the left and right counters of every layer, leaves with out_true=0 and out_tend=0, and produces no carry (cy_valid=0).
- R2: For orientation 0, an inherited point adds one to both counters of its layer, an edge start adds one to the right counter only, and an edge end adds one to the left counter only.
- R3: For orientation 1, the same three kinds subtract one from the same counters. An extension point changes no counter.
- R4: A side is covered when its counter is greater than zero. out_true is 1 when the point changes the covered state of at least one side of its layer.
- R5: out_tend is 1 when the point changes the covered state of exactly one side.
- R6: An edge end that is a boundary point spawns an extension point on the carry output (cy_valid=1, cy_d=0) in two cases. The first is orientation 0 with the right side uncovered after the update. The second is orientation 1 with the right side covered. The extension point keeps y, layer and orientation, and cy_xext is the layer's reach from parameter VEXT (layer k in bits [(k-1)*XEXT_W +: XEXT_W]).
- R7: An edge start is carried as an inherited point (cy_d=1, cy_xext=0). An incoming inherited point is carried with cy_d=1, and an incoming extension point with cy_d=0; both keep their xext. An edge end that spawns nothing gives cy_valid=0.
- R8: out_err is 1 when either counter of the point's layer is below zero after the update.
- R9: Every input cycle with in_valid=1 gives exactly one output cycle with out_valid=1 one clock later, with y, layer, orientation and kind bits unchanged. An idle input gives out_valid=0 and cy_valid=0.
- R10: A point changes only the counters of its own layer.
- R11: A layer code above NUM_LAYERS changes no counter and gives out_true=0, out_tend=0, out_err=0 and cy_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input point present |
| in_layer | input | $clog2(NUM_LAYERS+1) | Layer code, 0 = scanline marker |
| in_y | input | Y_W | Y coordinate, or X position on a marker |
| in_orient | input | 1 | Edge orientation, 1 = bounds shape from below |
| in_p | input | 1 | Kind bit p |
| in_d | input | 1 | Kind bit d |
| in_xext | input | XEXT_W | Remaining reach of an extension point |
| out_valid | output | 1 | Classified point present |
| out_layer | output | $clog2(NUM_LAYERS+1) | Layer code of the classified point |
| out_y | output | Y_W | Y of the classified point |
| out_orient | output | 1 | Orientation of the classified point |
| out_p | output | 1 | Kind bit p of the classified point |
| out_d | output | 1 | Kind bit d of the classified point |
| out_true | output | 1 | Boundary point |
| out_tend | output | 1 | Boundary endpoint |
| out_err | output | 1 | Counter of the layer below zero |
| cy_valid | output | 1 | Point carried to the next scanline |
| cy_layer | output | $clog2(NUM_LAYERS+1) | Layer of the carried point |
| cy_y | output | Y_W | Y of the carried point |
| cy_orient | output | 1 | Orientation of the carried point |
| cy_d | output | 1 | 1 = inherited point, 0 = extension point |
| cy_xext | output | XEXT_W | Reach of the carried point |

## Verification
The bench builds the block with NUM_LAYERS=2, Y_W=12 and reaches of 3 and 7 on the two layers. With two layers the layer field is two bits wide, so code 3 is a real out-of-range value that the stimulus can drive. Different reaches per layer show which layer's entry fed each spawned extension point. With only two layers, short sequences can take a counter below zero, stack coincident shapes, and show that one layer leaves the other alone.

// File: rtl/true_point_selector.sv
module true_point_selector #(
  parameter int NUM_LAYERS = 5,
  parameter int Y_W        = 18,
  parameter int CNT_W      = 8,
  parameter int XEXT_W     = 8,
  parameter logic [NUM_LAYERS*XEXT_W-1:0] VEXT = {8'd6, 8'd5, 8'd4, 8'd3, 8'd2}
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [$clog2(NUM_LAYERS+1)-1:0]   in_layer,
  input  logic [Y_W-1:0]                    in_y,
  input  logic                              in_orient,
  input  logic                              in_p,
  input  logic                              in_d,
  input  logic [XEXT_W-1:0]                 in_xext,
  output logic                              out_valid,
  output logic [$clog2(NUM_LAYERS+1)-1:0]   out_layer,
  output logic [Y_W-1:0]                    out_y,
  output logic                              out_orient,
  output logic                              out_p,
  output logic                              out_d,
  output logic                              out_true,
  output logic                              out_tend,
  output logic                              out_err,
  output logic                              cy_valid,
  output logic [$clog2(NUM_LAYERS+1)-1:0]   cy_layer,
  output logic [Y_W-1:0]                    cy_y,
  output logic                              cy_orient,
  output logic                              cy_d,
  output logic [XEXT_W-1:0]                 cy_xext
);
  localparam int LW = $clog2(NUM_LAYERS + 1);

  logic signed [CNT_W-1:0] lc [NUM_LAYERS];
  logic signed [CNT_W-1:0] rc [NUM_LAYERS];

  wire k_start = !in_p && !in_d;
  wire k_end   = !in_p &&  in_d;
  wire k_old   =  in_p &&  in_d;
  wire k_virt  =  in_p && !in_d;

  wire is_marker = in_valid && (in_layer == '0);
  wire in_range  = (in_layer != '0) && (in_layer <= LW'(NUM_LAYERS));
  wire is_pt     = in_valid && in_range;
  wire [LW-1:0] idx = in_range ? in_layer - LW'(1) : '0;

  wire signed [CNT_W-1:0] step = in_orient ? '1 : CNT_W'(1);
  wire signed [CNT_W-1:0] dl   = (k_old || k_end)   ? step : '0;
  wire signed [CNT_W-1:0] dr   = (k_old || k_start) ? step : '0;

  logic signed [CNT_W-1:0] lc_sel, rc_sel;
  always_comb begin
    lc_sel = '0;
    rc_sel = '0;
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (idx == LW'(i)) begin
        lc_sel = lc[i];
        rc_sel = rc[i];
      end
    end
  end

  wire signed [CNT_W-1:0] lc_new = lc_sel + dl;
  wire signed [CNT_W-1:0] rc_new = rc_sel + dr;

  function automatic logic covered(input logic [CNT_W-1:0] v);
    return !v[CNT_W-1] && (v != '0);
  endfunction

  wire ch_l = covered(lc_sel) ^ covered(lc_new);
  wire ch_r = covered(rc_sel) ^ covered(rc_new);

  wire tru  = is_pt && (ch_l || ch_r);
  wire tend = is_pt && (ch_l ^ ch_r);
  wire err  = is_pt && (lc_new[CNT_W-1] || rc_new[CNT_W-1]);

  wire spawn = is_pt && k_end && tru &&
               (in_orient ? covered(rc_new) : !covered(rc_new));
  wire carry = is_pt && (k_start || k_old || k_virt || spawn);

  wire [XEXT_W-1:0] reach = VEXT[idx*XEXT_W +: XEXT_W];
  wire [XEXT_W-1:0] xext_n = spawn ? reach : (k_start ? '0 : in_xext);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (!rst_n || is_marker) begin
        lc[i] <= '0;
        rc[i] <= '0;
      end else if (is_pt && idx == LW'(i)) begin
        lc[i] <= lc_new;
        rc[i] <= rc_new;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_layer  <= '0;
      out_y      <= '0;
      out_orient <= 1'b0;
      out_p      <= 1'b0;
      out_d      <= 1'b0;
      out_true   <= 1'b0;
      out_tend   <= 1'b0;
      out_err    <= 1'b0;
      cy_valid   <= 1'b0;
      cy_layer   <= '0;
      cy_y       <= '0;
      cy_orient  <= 1'b0;
      cy_d       <= 1'b0;
      cy_xext    <= '0;
    end else begin
      out_valid  <= in_valid;
      out_layer  <= in_layer;
      out_y      <= in_y;
      out_orient <= in_orient;
      out_p      <= in_p;
      out_d      <= in_d;
      out_true   <= tru;
      out_tend   <= tend;
      out_err    <= err;
      cy_valid   <= carry;
      cy_layer   <= in_layer;
      cy_y       <= in_y;
      cy_orient  <= in_orient;
      cy_d       <= !(k_virt || spawn);
      cy_xext    <= xext_n;
    end
  end
endmodule

// File: rtl/true_point_selector_chk.sv
module true_point_selector_chk #(
  parameter int NL  = 5,
  parameter int LW  = 3,
  parameter int Y_W = 18
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           out_valid,
  input logic [LW-1:0]  out_layer,
  input logic [Y_W-1:0] out_y,
  input logic           out_p,
  input logic           out_d,
  input logic           out_true,
  input logic           out_tend,
  input logic           cy_valid,
  input logic [LW-1:0]  cy_layer,
  input logic [Y_W-1:0] cy_y,
  input logic           cy_d
);
  wire out_start = out_valid && !out_p && !out_d;
  wire out_inr   = (out_layer != '0) && (out_layer <= LW'(NL));

  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && !cy_valid)); // R9
  AST_MARKER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_layer == '0) |-> (!out_true && !cy_valid)); // R1
  AST_TEND_IS_TRUE: assert property (@(posedge clk) disable iff (!rst_n) out_tend |-> out_true); // R5
  AST_START_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n) (out_start && out_true) |-> out_tend); // R2
  AST_START_CARRIED: assert property (@(posedge clk) disable iff (!rst_n) (out_start && out_inr) |-> (cy_valid && cy_d)); // R7
  AST_SPAWN_FROM_END: assert property (@(posedge clk) disable iff (!rst_n) (cy_valid && !cy_d && !out_p) |-> (out_d && out_tend)); // R6
  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) cy_valid |-> (cy_y == out_y && cy_layer == out_layer && out_inr)); // R7
  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_layer > LW'(NL)) |-> (!out_true && !cy_valid)); // R11
endmodule

bind true_point_selector true_point_selector_chk #(
  .NL(NUM_LAYERS), .LW($clog2(NUM_LAYERS+1)), .Y_W(Y_W)
) u_chk (.*);

// File: tb/true_point_selector_test.sv
module true_point_selector_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int LW = 2;
  localparam int YW = 12;
  localparam int XW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [LW-1:0] in_layer = '0;
  logic [YW-1:0] in_y = '0;
  logic in_orient = 0, in_p = 0, in_d = 0;
  logic [XW-1:0] in_xext = '0;
  logic out_valid, out_orient, out_p, out_d, out_true, out_tend, out_err;
  logic [LW-1:0] out_layer, cy_layer;
  logic [YW-1:0] out_y, cy_y;
  logic cy_valid, cy_orient, cy_d;
  logic [XW-1:0] cy_xext;

  always #(CLK_PERIOD/2) clk = ~clk;

  true_point_selector #(
    .NUM_LAYERS(NL), .Y_W(YW), .CNT_W(8), .XEXT_W(XW), .VEXT({8'd7, 8'd3})
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_layer(in_layer),
    .in_y(in_y), .in_orient(in_orient), .in_p(in_p), .in_d(in_d),
    .in_xext(in_xext), .out_valid(out_valid), .out_layer(out_layer),
    .out_y(out_y), .out_orient(out_orient), .out_p(out_p), .out_d(out_d),
    .out_true(out_true), .out_tend(out_tend), .out_err(out_err),
    .cy_valid(cy_valid), .cy_layer(cy_layer), .cy_y(cy_y),
    .cy_orient(cy_orient), .cy_d(cy_d), .cy_xext(cy_xext)
  );

  typedef struct packed {
    logic [1:0]  layer;
    logic [11:0] y;
    logic o, p, d;
    logic [7:0]  xi;
    logic t, te, er, cv, cd;
    logic [7:0]  cx;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 12'd100, 1'b0,1'b0,1'b0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0}, // R1 marker
    '{2'd1, 12'd10,  1'b0,1'b0,1'b0, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b1, 8'd0}, // R2 R7 start
    '{2'd1, 12'd20,  1'b1,1'b0,1'b0, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b1, 8'd0}, // R3 R5
    '{2'd2, 12'd15,  1'b0,1'b1,1'b1, 8'd0, 1'b1,1'b0,1'b0,1'b1,1'b1, 8'd0}, // R4 R10 both sides
    '{2'd2, 12'd25,  1'b1,1'b0,1'b1, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b0, 8'd7}, // R6 width spawn
    '{2'd2, 12'd30,  1'b1,1'b1,1'b1, 8'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 8'd0}, // R8 R3
    '{2'd0, 12'd101, 1'b0,1'b0,1'b0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0}, // R1
    '{2'd1, 12'd5,   1'b0,1'b0,1'b1, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b0, 8'd3}, // R6 spacing spawn
    '{2'd1, 12'd5,   1'b0,1'b1,1'b1, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b1, 8'd0}, // R2 R4 overlap
    '{2'd1, 12'd9,   1'b1,1'b1,1'b1, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b1, 8'd0}, // R3 R7
    '{2'd1, 12'd12,  1'b1,1'b0,1'b1, 8'd0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'd0}, // R6 no spawn
    '{2'd3, 12'd50,  1'b0,1'b0,1'b0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0}, // R11
    '{2'd2, 12'd60,  1'b0,1'b0,1'b1, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b0, 8'd7}, // R6 R10
    '{2'd2, 12'd61,  1'b0,1'b0,1'b1, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0}, // R4 stacked end
    '{2'd1, 12'd70,  1'b0,1'b1,1'b0, 8'd2, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2}, // R3 R7 extension
    '{2'd1, 12'd71,  1'b1,1'b0,1'b1, 8'd0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R8 underflow
    '{2'd1, 12'd80,  1'b0,1'b0,1'b0, 8'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 8'd0}, // R8 stays below zero
    '{2'd0, 12'd102, 1'b0,1'b0,1'b0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0}, // R1
    '{2'd1, 12'd81,  1'b0,1'b0,1'b0, 8'd0, 1'b1,1'b1,1'b0,1'b1,1'b1, 8'd0}  // R1 R8 cleared
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] l, input logic [11:0] y,
                       input logic o, input logic p, input logic d, input logic [7:0] xi);
    @(negedge clk);
    in_valid = v; in_layer = l; in_y = y; in_orient = o; in_p = p; in_d = d; in_xext = xi;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] act_word();
    return {out_valid, out_layer, out_y, out_orient, out_p, out_d,
            out_true, out_tend, out_err, cy_valid,
            cy_valid ? {cy_d, cy_xext, cy_y, cy_layer, cy_orient} : 24'd0};
  endfunction

  function automatic logic [63:0] exp_word(input vec_t v);
    return {1'b1, v.layer, v.y, v.o, v.p, v.d, v.t, v.te, v.er, v.cv,
            v.cv ? {v.cd, v.cx, v.y, v.layer, v.o} : 24'd0};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL R9 watchdog expired act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset state", {61'd0, out_valid, cy_valid, out_true}, 64'd0);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, TBL[i].layer, TBL[i].y, TBL[i].o, TBL[i].p, TBL[i].d, TBL[i].xi);
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R10 R11 vector %0d", i), act_word(), exp_word(TBL[i]));
    end

    drive(1'b0, 2'd0, 12'd0, 1'b0, 1'b0, 1'b0, 8'd0);
    check("R9 idle cycle", {62'd0, out_valid, cy_valid}, 64'd0);

    // R1: marker must clear a covered right counter on layer 2
    drive(1'b1, 2'd2, 12'd200, 1'b0, 1'b0, 1'b0, 8'd0);
    check("R1 setup start", {61'd0, out_true, out_tend, out_err}, 64'd6);
    drive(1'b1, 2'd0, 12'd103, 1'b0, 1'b0, 1'b0, 8'd0);
    drive(1'b1, 2'd2, 12'd201, 1'b1, 1'b0, 1'b0, 8'd0);
    check("R1 counters cleared by marker", {61'd0, out_true, out_tend, out_err}, 64'd1);
    drive(1'b1, 2'd0, 12'd104, 1'b0, 1'b0, 1'b0, 8'd0);

    // R10: layer 1 start leaves layer 2 untouched
    drive(1'b1, 2'd1, 12'd300, 1'b0, 1'b0, 1'b0, 8'd0);
    drive(1'b1, 2'd2, 12'd301, 1'b0, 1'b0, 1'b0, 8'd0);
    check("R10 layer 2 still uncovered", {61'd0, out_true, out_tend, out_err}, 64'd6);

    drive(1'b0, 2'd0, 12'd0, 1'b0, 1'b0, 1'b0, 8'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule